// File: doc/BRIEF.md
# Flow Table Slot Allocator

This block owns a table of flow entries held in on-chip RAM and places new entries into it. A requester presents a hash index, a 16-bit control word, a timestamp and a payload word. The allocator reads the slot at the hash index and, if that slot is taken, the slot just after it. It writes the entry into the first free one and answers with the slot it used, or with a no-space result. Every entry is written payload first and control word last, so an entry only becomes live when its control word lands. Each successful placement ends with a one-cycle pulse that tells a downstream lookup cache to flush.

Two table-wide sweeps share the write port with commits. The init sweep zeroes every entry and marks seven fixed slots in every 128-entry group as reserved. The stop sweep sets every control word to zero, so every entry becomes invalid, and leaves the payloads alone. A second read port lets the lookup side, and the testbench, read any entry with one cycle of latency.

Control word layout: bits [1:0] hold the entry state (0 invalid, 1 unbound, 2 bound, 3 static), bit 2 is the reserved flag, bits [7:3] are carried through unchanged, and bits [15:8] hold the timestamp. The FSM states are IDLE, PROBE_HOME, PROBE_NEXT, COMMIT, FULL, INIT and STOP. The transitions are:
- IDLE→INIT on start_init.
- IDLE→STOP on start_stop.
- IDLE→PROBE_HOME when a request is accepted.
- PROBE_HOME→COMMIT when the home slot is free.
- PROBE_HOME→PROBE_NEXT when the home slot is taken and not last.
- PROBE_HOME→FULL when the home slot is taken and last.
- PROBE_NEXT→COMMIT or FULL.
- COMMIT→IDLE and FULL→IDLE.
- INIT/STOP→IDLE after the last index.

Top module: `flow_slot_alloc`

## Requirements
- R1: The stored control word is the request control word with bits [15:8] replaced by req_ts[7:0]. Bits [15:8] of req_ctrl and req_ts are discarded.
- R2: When the home slot (req_hash) is free, the entry is placed there and rsp_idx equals req_hash with rsp_ok=1.
- R3: When the home slot is taken and req_hash+1 is free, the entry goes to req_hash+1 and rsp_idx equals req_hash+1.
- R4: When both probed slots are taken, rsp_ok=0 and neither slot's control word or payload changes.
- R5: A slot is free exactly when control bit 2 is 0 and bits [1:0] are not 2. Unbound (1) and state-3 entries without the flag are overwritten.
- R6: The payload is written in an earlier cycle than the control word of the same slot. After rsp_valid, a lookup returns both.
- R7: cache_clr is high for exactly one cycle, together with each rsp_valid that has rsp_ok=1, and never on a failed commit.
- R8: The init sweep leaves every payload 0 and every control word 0, except control 0x0004 at offsets 12, 25, 38, 51, 76, 89 and 102 of each 128-entry group. A commit hashed onto such a slot goes to the next slot.
- R9: The stop sweep sets every control word to 0 and keeps every payload.
- R10: A request at the last index whose home slot is taken fails. There is no wrap to index 0.
- R11: req_ready is low while a probe, commit or sweep is under way. When a sweep start and req_valid arrive in the same cycle, the sweep wins and the request is not accepted.
- R12: After reset, req_ready=1, rsp_valid=0 and cache_clr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_init | input | 1 | Pulse: start the init sweep |
| start_stop | input | 1 | Pulse: start the stop sweep |
| req_valid | input | 1 | Commit request present |
| req_ready | output | 1 | Commit request accepted this cycle when valid |
| req_hash | input | IDX_W | Home slot index |
| req_ctrl | input | 16 | Control word of the new entry |
| req_ts | input | 16 | Timestamp, masked to 8 bits |
| req_payload | input | PAY_W | Entry payload |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | 1 = placed, 0 = no space |
| rsp_idx | output | IDX_W | Slot used |
| cache_clr | output | 1 | One-cycle cache flush pulse |
| lk_idx | input | IDX_W | Lookup read index |
| lk_ctrl | output | 16 | Control word at lk_idx, one cycle later |
| lk_payload | output | PAY_W | Payload at lk_idx, one cycle later |

## Verification
A sweep start and a commit request can arrive in the same cycle. The bench raises start_stop and req_valid on the same clock edge while the block is idle. It then checks three things: req_ready is low in that cycle, no rsp_valid appears during the sweep, and the control word at the requested hash reads back as zero with no new payload written. A second pairing is the home-slot write and the probe of the next slot, which the vector table drives through reserved, bound and unbound neighbours.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
    localparam int CTRL_W   = 16;
    localparam int TS_IN_W  = 16;
    localparam int TS_LSB   = 8;
    localparam int TS_W     = 8;
    localparam int RSV_BIT  = 2;
    localparam int GROUP_W  = 7;
    localparam logic [1:0] ST_BIND = 2'd2;
    localparam logic [CTRL_W-1:0] RSV_WORD = CTRL_W'(1) << RSV_BIT;

    typedef enum logic [2:0] {
        S_IDLE, S_PROBE_HOME, S_PROBE_NEXT, S_COMMIT, S_FULL, S_INIT, S_STOP
    } fsa_state_e;

    function automatic logic slot_free(input logic [CTRL_W-1:0] c);
        return !c[RSV_BIT] && (c[1:0] != ST_BIND);
    endfunction

    function automatic logic reserved_ofs(input logic [GROUP_W-1:0] o);
        return o inside {7'd12, 7'd25, 7'd38, 7'd51, 7'd76, 7'd89, 7'd102};
    endfunction
endpackage

// File: rtl/fsa_table_ram.sv
module fsa_table_ram #(
    parameter int IDX_W = 8,
    parameter int PAY_W = 32
) (
    input  logic                       clk,
    input  logic [IDX_W-1:0]           a_addr,
    input  logic                       a_ctrl_we,
    input  logic [fsa_pkg::CTRL_W-1:0] a_ctrl_wd,
    input  logic                       a_pay_we,
    input  logic [PAY_W-1:0]           a_pay_wd,
    output logic [fsa_pkg::CTRL_W-1:0] a_ctrl_rd,
    input  logic [IDX_W-1:0]           b_addr,
    output logic [fsa_pkg::CTRL_W-1:0] b_ctrl_rd,
    output logic [PAY_W-1:0]           b_pay_rd
);
    localparam int DEPTH = 1 << IDX_W;

    logic [fsa_pkg::CTRL_W-1:0] mem_ctrl [DEPTH];
    logic [PAY_W-1:0]           mem_pay  [DEPTH];

    always_ff @(posedge clk) begin
        if (a_ctrl_we) mem_ctrl[a_addr] <= a_ctrl_wd;
        if (a_pay_we)  mem_pay[a_addr]  <= a_pay_wd;
        a_ctrl_rd <= mem_ctrl[a_addr];
        b_ctrl_rd <= mem_ctrl[b_addr];
        b_pay_rd  <= mem_pay[b_addr];
    end
endmodule

// File: rtl/fsa_sweep_pattern.sv
module fsa_sweep_pattern #(
    parameter int IDX_W = 8
) (
    input  logic                       is_init,
    input  logic [IDX_W-1:0]           idx,
    output logic [fsa_pkg::CTRL_W-1:0] ctrl_wd,
    output logic                       pay_clear
);
    localparam int OFS_W = (IDX_W < fsa_pkg::GROUP_W) ? IDX_W : fsa_pkg::GROUP_W;

    logic [fsa_pkg::GROUP_W-1:0] ofs;

    always_comb begin
        ofs       = fsa_pkg::GROUP_W'(idx[OFS_W-1:0]);
        pay_clear = is_init;
        ctrl_wd   = '0;
        if (is_init && fsa_pkg::reserved_ofs(ofs))
            ctrl_wd = fsa_pkg::RSV_WORD;
    end
endmodule

// File: rtl/fsa_ctrl.sv
module fsa_ctrl #(
    parameter int IDX_W = 8,
    parameter int PAY_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_init,
    input  logic                        start_stop,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [IDX_W-1:0]            req_hash,
    input  logic [fsa_pkg::CTRL_W-1:0]  req_ctrl,
    input  logic [fsa_pkg::TS_IN_W-1:0] req_ts,
    input  logic [PAY_W-1:0]            req_payload,
    output logic                        rsp_valid,
    output logic                        rsp_ok,
    output logic [IDX_W-1:0]            rsp_idx,
    output logic                        cache_clr,
    output logic [IDX_W-1:0]            ram_addr,
    output logic                        ram_ctrl_we,
    output logic [fsa_pkg::CTRL_W-1:0]  ram_ctrl_wd,
    output logic                        ram_pay_we,
    output logic [PAY_W-1:0]            ram_pay_wd,
    input  logic [fsa_pkg::CTRL_W-1:0]  ram_ctrl_rd
);
    import fsa_pkg::*;

    localparam logic [IDX_W-1:0] LAST = '1;

    fsa_state_e        state, state_nx;
    logic [IDX_W-1:0]  hash_q, slot_q, sweep_idx;
    logic [CTRL_W-1:0] ctrl_q, merged;
    logic [PAY_W-1:0]  pay_q;
    logic [IDX_W-1:0]  hash_next;
    logic              probe_free, accept;
    logic [CTRL_W-1:0] pat_ctrl;
    logic              pat_pay_clear;
    logic              unused_hi;

    assign unused_hi  = ^{req_ts[TS_IN_W-1:TS_W]};
    assign hash_next  = hash_q + IDX_W'(1);
    assign probe_free = slot_free(ram_ctrl_rd);
    assign req_ready  = (state == S_IDLE) && !start_init && !start_stop;
    assign accept     = req_valid && req_ready;

    always_comb begin
        merged = req_ctrl;
        merged[TS_LSB +: TS_W] = req_ts[TS_W-1:0];
    end

    fsa_sweep_pattern #(.IDX_W(IDX_W)) u_pat (
        .is_init  (state == S_INIT),
        .idx      (sweep_idx),
        .ctrl_wd  (pat_ctrl),
        .pay_clear(pat_pay_clear)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start_init)      state_nx = S_INIT;
                else if (start_stop) state_nx = S_STOP;
                else if (req_valid)  state_nx = S_PROBE_HOME;
            end
            S_PROBE_HOME: begin
                if (probe_free)          state_nx = S_COMMIT;
                else if (hash_q == LAST) state_nx = S_FULL;
                else                     state_nx = S_PROBE_NEXT;
            end
            S_PROBE_NEXT: state_nx = probe_free ? S_COMMIT : S_FULL;
            S_COMMIT:     state_nx = S_IDLE;
            S_FULL:       state_nx = S_IDLE;
            S_INIT, S_STOP: if (sweep_idx == LAST) state_nx = S_IDLE;
            default:      state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            hash_q    <= '0;
            slot_q    <= '0;
            ctrl_q    <= '0;
            pay_q     <= '0;
            sweep_idx <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                hash_q <= req_hash;
                ctrl_q <= merged;
                pay_q  <= req_payload;
            end
            if (state == S_PROBE_HOME)
                slot_q <= probe_free ? hash_q : hash_next;
            if (state == S_INIT || state == S_STOP)
                sweep_idx <= sweep_idx + IDX_W'(1);
            else
                sweep_idx <= '0;
        end
    end

    always_comb begin
        ram_addr    = hash_q;
        ram_ctrl_we = 1'b0;
        ram_ctrl_wd = ctrl_q;
        ram_pay_we  = 1'b0;
        ram_pay_wd  = pay_q;
        rsp_valid   = 1'b0;
        rsp_ok      = 1'b0;
        cache_clr   = 1'b0;
        unique case (state)
            S_IDLE: ram_addr = req_hash;
            S_PROBE_HOME: begin
                ram_addr   = probe_free ? hash_q : hash_next;
                ram_pay_we = probe_free;
            end
            S_PROBE_NEXT: begin
                ram_addr   = hash_next;
                ram_pay_we = probe_free;
            end
            S_COMMIT: begin
                ram_addr    = slot_q;
                ram_ctrl_we = 1'b1;
                rsp_valid   = 1'b1;
                rsp_ok      = 1'b1;
                cache_clr   = 1'b1;
            end
            S_FULL: rsp_valid = 1'b1;
            S_INIT, S_STOP: begin
                ram_addr    = sweep_idx;
                ram_ctrl_we = 1'b1;
                ram_ctrl_wd = pat_ctrl;
                ram_pay_we  = pat_pay_clear;
                ram_pay_wd  = '0;
            end
            default: ;
        endcase
    end
    assign rsp_idx = slot_q;

    assert_ctrl_after_payload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COMMIT) |-> ($past(ram_pay_we) && $past(ram_addr) == ram_addr));

    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_clr_only_on_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cache_clr |-> (rsp_valid && rsp_ok));

    assert_slot_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> (rsp_idx == hash_q || rsp_idx == hash_next));

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok && hash_q == LAST) |-> (rsp_idx == LAST));

    assert_hold_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
endmodule

// File: rtl/flow_slot_alloc.sv
module flow_slot_alloc #(
    parameter int IDX_W = 8,
    parameter int PAY_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_init,
    input  logic               start_stop,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [IDX_W-1:0]   req_hash,
    input  logic [15:0]        req_ctrl,
    input  logic [15:0]        req_ts,
    input  logic [PAY_W-1:0]   req_payload,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic [IDX_W-1:0]   rsp_idx,
    output logic               cache_clr,
    input  logic [IDX_W-1:0]   lk_idx,
    output logic [15:0]        lk_ctrl,
    output logic [PAY_W-1:0]   lk_payload
);
    logic [IDX_W-1:0]            ram_addr;
    logic                        ram_ctrl_we, ram_pay_we;
    logic [fsa_pkg::CTRL_W-1:0]  ram_ctrl_wd, ram_ctrl_rd;
    logic [PAY_W-1:0]            ram_pay_wd;

    fsa_ctrl #(.IDX_W(IDX_W), .PAY_W(PAY_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_init (start_init),
        .start_stop (start_stop),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_hash   (req_hash),
        .req_ctrl   (req_ctrl),
        .req_ts     (req_ts),
        .req_payload(req_payload),
        .rsp_valid  (rsp_valid),
        .rsp_ok     (rsp_ok),
        .rsp_idx    (rsp_idx),
        .cache_clr  (cache_clr),
        .ram_addr   (ram_addr),
        .ram_ctrl_we(ram_ctrl_we),
        .ram_ctrl_wd(ram_ctrl_wd),
        .ram_pay_we (ram_pay_we),
        .ram_pay_wd (ram_pay_wd),
        .ram_ctrl_rd(ram_ctrl_rd)
    );

    fsa_table_ram #(.IDX_W(IDX_W), .PAY_W(PAY_W)) u_ram (
        .clk      (clk),
        .a_addr   (ram_addr),
        .a_ctrl_we(ram_ctrl_we),
        .a_ctrl_wd(ram_ctrl_wd),
        .a_pay_we (ram_pay_we),
        .a_pay_wd (ram_pay_wd),
        .a_ctrl_rd(ram_ctrl_rd),
        .b_addr   (lk_idx),
        .b_ctrl_rd(lk_ctrl),
        .b_pay_rd (lk_payload)
    );

    assert_ok_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> rsp_valid);
endmodule

// File: tb/sim_flow_slot_alloc.sv
module sim_flow_slot_alloc;
    localparam int IDX_W = 8;
    localparam int PAY_W = 32;
    localparam int DEPTH = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_init = 1'b0, start_stop = 1'b0, req_valid = 1'b0;
    logic req_ready, rsp_valid, rsp_ok, cache_clr;
    logic [IDX_W-1:0] req_hash = '0, rsp_idx, lk_idx = '0;
    logic [15:0] req_ctrl = '0, req_ts = '0, lk_ctrl;
    logic [PAY_W-1:0] req_payload = '0, lk_payload;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    flow_slot_alloc #(.IDX_W(IDX_W), .PAY_W(PAY_W)) u0 (.*);

    typedef struct packed {
        logic [7:0]  hash;
        logic [15:0] ctrl;
        logic [15:0] ts;
        logic [31:0] pay;
        logic        ok;
        logic [7:0]  idx;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'd5,   16'hAB02, 16'h9934, 32'h1111_0005, 1'b1, 8'd5},
        '{8'd5,   16'h0002, 16'h0001, 32'h2222_0006, 1'b1, 8'd6},
        '{8'd5,   16'h0002, 16'h0002, 32'h3333_0000, 1'b0, 8'd0},
        '{8'd12,  16'h0002, 16'h0003, 32'h4444_000D, 1'b1, 8'd13},
        '{8'd140, 16'h0001, 16'h0004, 32'h5555_008D, 1'b1, 8'd141},
        '{8'd140, 16'h0002, 16'h0005, 32'h6666_008D, 1'b1, 8'd141},
        '{8'd255, 16'h0002, 16'h0006, 32'h7777_00FF, 1'b1, 8'd255},
        '{8'd255, 16'h0002, 16'h0007, 32'h8888_0000, 1'b0, 8'd0},
        '{8'd20,  16'h0003, 16'h0008, 32'h9999_0014, 1'b1, 8'd20},
        '{8'd20,  16'h0002, 16'h0009, 32'hAAAA_0014, 1'b1, 8'd20},
        '{8'd30,  16'h0006, 16'h000A, 32'hBBBB_001E, 1'b1, 8'd30},
        '{8'd30,  16'h0001, 16'h000B, 32'hCCCC_001F, 1'b1, 8'd31},
        '{8'd30,  16'h0002, 16'h000C, 32'hDDDD_001F, 1'b1, 8'd31}
    };

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [IDX_W-1:0] idx,
                          output logic [15:0] c, output logic [PAY_W-1:0] p);
        lk_idx = idx;
        @(negedge clk);
        c = lk_ctrl;
        p = lk_payload;
    endtask

    task automatic sweep(input logic is_init, output int rsp_seen, output logic busy_seen);
        rsp_seen = 0;
        if (is_init) start_init = 1'b1; else start_stop = 1'b1;
        @(negedge clk);
        start_init = 1'b0;
        start_stop = 1'b0;
        busy_seen = !req_ready;
        for (int i = 0; i < DEPTH + 8 && !req_ready; i++) begin
            if (rsp_valid) rsp_seen++;
            @(negedge clk);
        end
    endtask

    task automatic commit(input vec_t v, output logic got, output logic ok,
                          output logic [IDX_W-1:0] idx, output int clr_cnt);
        got = 1'b0; ok = 1'b0; idx = '0; clr_cnt = 0;
        req_valid = 1'b1;
        req_hash = v.hash;
        req_ctrl = v.ctrl;
        req_ts = v.ts;
        req_payload = v.pay;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (cache_clr) clr_cnt++;
            if (rsp_valid) begin
                got = 1'b1;
                ok = rsp_ok;
                idx = rsp_idx;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] c;
        logic [PAY_W-1:0] p;
        logic got, ok, busy_seen;
        logic [IDX_W-1:0] idx;
        int clr, rsp_seen, bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: idle outputs after reset
        check(req_ready === 1'b1, "R12", "req_ready", 32'(req_ready), 32'd1);
        check(rsp_valid === 1'b0, "R12", "rsp_valid", 32'(rsp_valid), 32'd0);
        check(cache_clr === 1'b0, "R12", "cache_clr", 32'(cache_clr), 32'd0);

        // R8 init sweep, R11 busy during sweep
        sweep(1'b1, rsp_seen, busy_seen);
        check(busy_seen, "R11", "ready low during init", 32'(!busy_seen), 32'd0);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [6:0] o;
            logic [15:0] e;
            o = 7'(i);
            e = (o inside {7'd12, 7'd25, 7'd38, 7'd51, 7'd76, 7'd89, 7'd102}) ? 16'h0004 : 16'h0000;
            lookup(IDX_W'(i), c, p);
            if (c !== e || p !== '0) begin
                if (bad == 0) check(1'b0, "R8", "init entry", {c, 16'(i)}, {e, 16'(i)});
                bad++;
            end
        end
        if (bad == 0) check(1'b1, "R8", "init table", 0, 0);

        // R1 R2 R3 R4 R5 R7 R8 R10: vector walk
        for (int v = 0; v < NV; v++) begin
            commit(VECS[v], got, ok, idx, clr);
            check(got === 1'b1, "R2", $sformatf("vec%0d response", v), 32'(got), 32'd1);
            check(ok === VECS[v].ok, "R4 R10", $sformatf("vec%0d ok", v), 32'(ok), 32'(VECS[v].ok));
            check(clr == int'(VECS[v].ok), "R7", $sformatf("vec%0d cache_clr cycles", v),
                  32'(clr), 32'(VECS[v].ok));
            if (VECS[v].ok) begin
                check(idx === VECS[v].idx, "R3 R5 R8", $sformatf("vec%0d idx", v),
                      32'(idx), 32'(VECS[v].idx));
                lookup(VECS[v].idx, c, p);
                check(c === {VECS[v].ts[7:0], VECS[v].ctrl[7:0]}, "R1", $sformatf("vec%0d ctrl", v),
                      32'(c), 32'({VECS[v].ts[7:0], VECS[v].ctrl[7:0]}));
                check(p === VECS[v].pay, "R6", $sformatf("vec%0d payload", v), p, VECS[v].pay);
            end
        end

        // R4: failed commits left slots 5, 6 and 255 untouched
        lookup(8'd5, c, p);
        check(c === 16'h3402 && p === 32'h1111_0005, "R4", "slot5 kept", {c, p[15:0]}, 32'h3402_0005);
        lookup(8'd6, c, p);
        check(c === 16'h0102 && p === 32'h2222_0006, "R4", "slot6 kept", {c, p[15:0]}, 32'h0102_0006);
        lookup(8'd255, c, p);
        check(c === 16'h0602 && p === 32'h7777_00FF, "R10", "slot255 kept", {c, p[15:0]}, 32'h0602_00FF);

        // R11: sweep start and request in the same cycle; sweep wins
        req_valid = 1'b1;
        req_hash = 8'd40;
        req_ctrl = 16'h0002;
        req_ts = 16'h0055;
        req_payload = 32'hFEED_0028;
        check(req_ready === 1'b1, "R11", "ready before collision", 32'(req_ready), 32'd1);
        start_stop = 1'b1;
        #0;
        check(req_ready === 1'b0, "R11", "ready low in collision cycle", 32'(req_ready), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        start_stop = 1'b0;
        rsp_seen = 0;
        for (int i = 0; i < DEPTH + 8 && !req_ready; i++) begin
            if (rsp_valid) rsp_seen++;
            @(negedge clk);
        end
        check(rsp_seen == 0, "R11", "no response to dropped request", 32'(rsp_seen), 32'd0);
        lookup(8'd40, c, p);
        check(c === 16'h0000 && p === 32'h0, "R11", "slot40 not written", {c, p[15:0]}, 32'h0);

        // R9: stop sweep cleared every control word, payloads kept
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            lookup(IDX_W'(i), c, p);
            if (c !== 16'h0000) begin
                if (bad == 0) check(1'b0, "R9", "ctrl after stop", {c, 16'(i)}, {16'h0, 16'(i)});
                bad++;
            end
        end
        if (bad == 0) check(1'b1, "R9", "ctrl after stop", 0, 0);
        lookup(8'd141, c, p);
        check(p === 32'h6666_008D, "R9", "payload kept", p, 32'h6666_008D);

        // R9 R2: a freed slot is reused at the home index
        commit('{8'd5, 16'h0002, 16'h0010, 32'h0BAD_0005, 1'b1, 8'd5}, got, ok, idx, clr);
        check(got && ok && idx == 8'd5, "R9", "reuse after stop", 32'(idx), 32'd5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule